// File: doc/BRIEF.md
# Bidirectional Multi-Step DCO Unit Shifter

This block is the frequency-control stage of an all-digital PLL. It sits between the digital loop filter and a ring oscillator whose strength is set by a matrix of inverter units laid out in rows and columns. On each update, the loop filter hands the block a small signed step. The block then enables or disables that many units in one clock edge, walking through the matrix in raster order. When the active row fills it carries into the next row, and when the active row empties it borrows from the row below.

The matrix is driven directly by two registered thermometer codes. The row code marks the rows that are fully on. The column code marks the columns that are on in the one partly filled row. No binary-to-thermometer stage or DAC sits downstream. The unit count stops at zero and at the full matrix size, and a full or empty flag reports any update that had to be clipped. After reset the matrix starts from a count set by a parameter, which defaults to mid-scale.

Top module: `dco_unit_shifter`

## Requirements
- R1: After reset, row_on has its lowest START_UNITS/COLS bits set, col_on has its lowest START_UNITS%COLS bits set, and both flags are low. With the defaults this is row_on = 16'h00FF, col_on = 0.
- R2: On a clock edge where update_valid is low, row_on, col_on, at_full and at_empty keep their values.
- R3: The unit count is defined as COLS times the number of ones in row_on plus the number of ones in col_on. A positive step on an accepted update raises the count by exactly that step when the result stays within range.
- R4: A negative step on an accepted update lowers the unit count by its magnitude when the result stays within range.
- R5: A zero step on an accepted update leaves both codes unchanged and clears both flags.
- R6: If the column position plus the step reaches COLS or more, one more row turns fully on and the column position wraps to the remainder in the same update.
- R7: If the column position plus the step falls below zero, one fully-on row turns off and the column position wraps to COLS plus the negative sum in the same update.
- R8: Both codes are always thermometers filled from bit 0 upward, and col_on is all zero whenever every bit of row_on is set.
- R9: A step that would push the count above ROWS*COLS leaves it at ROWS*COLS (all rows on, no columns) and sets at_full. Landing exactly on ROWS*COLS does not set at_full.
- R10: A step that would push the count below zero leaves it at zero and sets at_empty. Landing exactly on zero does not set at_empty.
- R11: The flags are reloaded on every accepted update, so an update that is not clipped clears them, and they are never both high.
- R12: step_in is a 5-bit two's-complement number, so 5'b01111 means +15 and 5'b10000 means -16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| update_valid | input | 1 | Accept step_in on this clock edge |
| step_in | input | STEP_W | Signed unit step from the loop filter |
| row_on | output | ROWS | Thermometer of fully enabled rows |
| col_on | output | COLS | Thermometer of enabled columns in the active row |
| at_full | output | 1 | The last update was clipped at the full matrix |
| at_empty | output | 1 | The last update was clipped at zero units |

## Verification
The internal state is a row pointer and a column position, and both outputs come straight from registers loaded from them. A wrong carry or borrow therefore shows up in the very next cycle as a unit count off by COLS, or as a column code outside its range. Because every later step builds on the stored position, such an error then persists for every following update. Wrong clipping shows up as a flag in the wrong cycle, or as a count that runs past a bound. The bench checks both codes and both flags after every clock edge, whether or not an update was applied, so any such slip is caught in the cycle it first appears.

// File: rtl/dus_pkg.sv
package dus_pkg;

  // Which way the column sum moved relative to the active row
  typedef enum logic [1:0] {
    CARRY_NONE = 2'd0,
    CARRY_UP   = 2'd1,
    CARRY_DOWN = 2'd2
  } carry_e;

endpackage

// File: rtl/dus_step_calc.sv
module dus_step_calc
  import dus_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int STEP_W = 5,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 4
) (
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  input  logic [STEP_W-1:0] step,
  output logic [ROW_W-1:0]  row_d,
  output logic [COL_W-1:0]  col_d,
  output logic              clip_hi,
  output logic              clip_lo
);

  // Signed working widths large enough for one carry or borrow
  localparam int SW = ((COL_W > STEP_W) ? COL_W : STEP_W) + 2;
  localparam int RW = ROW_W + 2;
  localparam logic signed [SW-1:0] COLS_S  = SW'(COLS);
  localparam logic signed [RW-1:0] ROWS_S  = RW'(ROWS);
  localparam logic signed [RW-1:0] ROW_ONE = RW'(1);

  logic signed [SW-1:0] col_ext;
  logic signed [SW-1:0] step_ext;
  logic signed [SW-1:0] col_sum;
  logic signed [SW-1:0] col_wrap;
  logic signed [RW-1:0] row_ext;
  logic signed [RW-1:0] row_move;
  carry_e               carry;

  // Column sum and boundary classification
  always_comb begin
    col_ext  = signed'({{(SW-COL_W){1'b0}}, col_q});
    step_ext = signed'({{(SW-STEP_W){step[STEP_W-1]}}, step});
    col_sum  = col_ext + step_ext;
    row_ext  = signed'({2'b00, row_q});
    if (col_sum[SW-1]) begin
      carry = CARRY_DOWN;
    end else if (col_sum >= COLS_S) begin
      carry = CARRY_UP;
    end else begin
      carry = CARRY_NONE;
    end
  end

  // Row pointer moves by at most one, column wraps
  always_comb begin
    unique case (carry)
      CARRY_UP: begin
        row_move = row_ext + ROW_ONE;
        col_wrap = col_sum - COLS_S;
      end
      CARRY_DOWN: begin
        row_move = row_ext - ROW_ONE;
        col_wrap = col_sum + COLS_S;
      end
      default: begin
        row_move = row_ext;
        col_wrap = col_sum;
      end
    endcase
  end

  // Saturation at both ends of the matrix
  always_comb begin
    clip_lo = row_move[RW-1];
    clip_hi = !clip_lo &&
              ((row_move > ROWS_S) || ((row_move == ROWS_S) && (col_wrap != '0)));
    if (clip_hi) begin
      row_d = ROW_W'(ROWS);
      col_d = '0;
    end else if (clip_lo) begin
      row_d = '0;
      col_d = '0;
    end else begin
      row_d = row_move[ROW_W-1:0];
      col_d = col_wrap[COL_W-1:0];
    end
  end

endmodule

// File: rtl/dus_therm_enc.sv
module dus_therm_enc #(
  parameter int N  = 16,
  parameter int VW = 5
) (
  input  logic [VW-1:0] level,
  output logic [N-1:0]  therm
);

  // Bit i is on when the level exceeds i
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign therm[i] = (level > VW'(i));
  end

endmodule

// File: rtl/dco_unit_shifter.sv
module dco_unit_shifter #(
  parameter int ROWS        = 16,
  parameter int COLS        = 16,
  parameter int STEP_W      = 5,
  parameter int START_UNITS = (ROWS * COLS) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update_valid,
  input  logic [STEP_W-1:0] step_in,
  output logic [ROWS-1:0]   row_on,
  output logic [COLS-1:0]   col_on,
  output logic              at_full,
  output logic              at_empty
);

  localparam int ROW_W     = $clog2(ROWS + 1);
  localparam int COL_W     = $clog2(COLS);
  localparam int START_ROW = START_UNITS / COLS;
  localparam int START_COL = START_UNITS % COLS;
  localparam logic [ROWS-1:0] ROW_ON_RST = {ROWS{1'b1}} >> (ROWS - START_ROW);
  localparam logic [COLS-1:0] COL_ON_RST = {COLS{1'b1}} >> (COLS - START_COL);

  // Reset release synchronizer
  logic rst_meta_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  // State and registered outputs
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [ROWS-1:0]  row_on_q, row_on_n;
  logic [COLS-1:0]  col_on_q, col_on_n;
  logic             full_q, full_n;
  logic             empty_q, empty_n;

  logic [ROW_W-1:0] calc_row;
  logic [COL_W-1:0] calc_col;
  logic             calc_hi;
  logic             calc_lo;
  logic [ROWS-1:0]  enc_row;
  logic [COLS-1:0]  enc_col;

  dus_step_calc #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .STEP_W (STEP_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_calc (
    .row_q   (row_q),
    .col_q   (col_q),
    .step    (step_in),
    .row_d   (calc_row),
    .col_d   (calc_col),
    .clip_hi (calc_hi),
    .clip_lo (calc_lo)
  );

  dus_therm_enc #(
    .N  (ROWS),
    .VW (ROW_W)
  ) u_row_enc (
    .level (calc_row),
    .therm (enc_row)
  );

  dus_therm_enc #(
    .N  (COLS),
    .VW (COL_W)
  ) u_col_enc (
    .level (calc_col),
    .therm (enc_col)
  );

  // Next-state selection with explicit clock enable
  always_comb begin
    row_n    = row_q;
    col_n    = col_q;
    row_on_n = row_on_q;
    col_on_n = col_on_q;
    full_n   = full_q;
    empty_n  = empty_q;
    if (update_valid) begin
      row_n    = calc_row;
      col_n    = calc_col;
      row_on_n = enc_row;
      col_on_n = enc_col;
      full_n   = calc_hi;
      empty_n  = calc_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      row_q    <= ROW_W'(START_ROW);
      col_q    <= COL_W'(START_COL);
      row_on_q <= ROW_ON_RST;
      col_on_q <= COL_ON_RST;
      full_q   <= 1'b0;
      empty_q  <= 1'b0;
    end else begin
      row_q    <= row_n;
      col_q    <= col_n;
      row_on_q <= row_on_n;
      col_on_q <= col_on_n;
      full_q   <= full_n;
      empty_q  <= empty_n;
    end
  end

  assign row_on   = row_on_q;
  assign col_on   = col_on_q;
  assign at_full  = full_q;
  assign at_empty = empty_q;

  // Checks beside the state they guard
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !update_valid |=> $stable(row_on) && $stable(col_on) &&
                      $stable(at_full) && $stable(at_empty)); // R2

  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (update_valid && (step_in == '0)) |=> $stable(row_on) && $stable(col_on) &&
                                          !at_full && !at_empty); // R5

  AST_ROW_THERM: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((row_on + ROWS'(1)) & row_on) == '0); // R8

  AST_COL_THERM: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((col_on + COLS'(1)) & col_on) == '0); // R8

  AST_TOP_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (&row_on) |-> (col_on == '0)); // R8

  AST_FULL_SHAPE: assert property (@(posedge clk) disable iff (!rst_core_n)
    at_full |-> ((&row_on) && (col_on == '0))); // R9

  AST_EMPTY_SHAPE: assert property (@(posedge clk) disable iff (!rst_core_n)
    at_empty |-> ((row_on == '0) && (col_on == '0))); // R10

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(at_full && at_empty)); // R11

endmodule

// File: tb/dco_unit_shifter_tb.sv
`timescale 1ns/1ps
module dco_unit_shifter_tb;

  localparam int ROWS  = 16;
  localparam int COLS  = 16;
  localparam int TOTAL = ROWS * COLS;

  logic            clk;
  logic            rst_n;
  logic            update_valid;
  logic [4:0]      step_in;
  logic [ROWS-1:0] row_on;
  logic [COLS-1:0] col_on;
  logic            at_full;
  logic            at_empty;

  typedef struct {
    int    cnt;
    bit    full;
    bit    empty;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   model_cnt;
  bit   model_full;
  bit   model_empty;
  bit   drive_done = 0;

  dco_unit_shifter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .update_valid (update_valid),
    .step_in      (step_in),
    .row_on       (row_on),
    .col_on       (col_on),
    .at_full      (at_full),
    .at_empty     (at_empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic compare(input exp_t e);
    logic [ROWS-1:0] er;
    logic [COLS-1:0] ec;
    for (int i = 0; i < ROWS; i++) er[i] = (i < e.cnt / COLS);
    for (int j = 0; j < COLS; j++) ec[j] = (j < e.cnt % COLS);
    n_checks++;
    if (row_on !== er || col_on !== ec || at_full !== e.full || at_empty !== e.empty) begin
      n_fail++;
      $display("FAIL %s: got row=%h col=%h full=%b empty=%b, expected row=%h col=%h full=%b empty=%b",
               e.tag, row_on, col_on, at_full, at_empty, er, ec, e.full, e.empty);
    end
  endtask

  // Driver: one item per driven cycle
  task automatic cyc(input bit v, input int s, input string tag);
    exp_t e;
    int   nxt;
    update_valid = v;
    step_in      = 5'(s);
    if (v) begin
      nxt         = model_cnt + s;
      model_full  = (nxt > TOTAL);
      model_empty = (nxt < 0);
      if (nxt > TOTAL) nxt = TOTAL;
      if (nxt < 0) nxt = 0;
      model_cnt = nxt;
    end
    e.cnt = model_cnt; e.full = model_full; e.empty = model_empty; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: pop after the edge that consumed the item
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        compare(e);
      end
    end
  end

  initial begin
    int seed;
    exp_t r;
    rst_n = 1'b0; update_valid = 1'b0; step_in = '0;
    model_cnt = TOTAL / 2; model_full = 0; model_empty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    r.cnt = TOTAL / 2; r.full = 0; r.empty = 0; r.tag = "R1 reset state";
    compare(r);

    cyc(0, 7, "R2 idle hold");
    cyc(0, -9, "R2 idle hold");
    cyc(1, 5, "R3 positive step");
    cyc(1, 15, "R6 carry up");
    cyc(1, -16, "R7 borrow down R12 min code");
    cyc(1, 0, "R5 zero step");
    cyc(1, -4, "R4 negative step to row edge");
    cyc(1, -1, "R7 borrow at column zero");
    for (int k = 0; k < 8; k++) cyc(1, 15, "R3 R12 max code climb");
    cyc(1, 9, "R9 exact full no flag");
    cyc(1, 1, "R9 clip full");
    cyc(0, 3, "R11 flag holds idle");
    cyc(1, 15, "R9 clip full again");
    cyc(1, 0, "R11 flag cleared");
    for (int k = 0; k < 16; k++) cyc(1, -16, "R4 descend");
    cyc(1, -1, "R10 clip empty");
    cyc(1, -16, "R10 clip empty again");
    cyc(1, 3, "R11 flag cleared");
    seed = 32'h1d3;
    for (int k = 0; k < 60; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      cyc((seed & 7) != 0, ((seed >> 8) % 32) - 16, "R8 mixed pattern");
    end
    update_valid = 1'b0;
    repeat (3) @(negedge clk);
    drive_done = 1;
  end

  initial begin
    int cycles = 0;
    while (!drive_done && cycles < 200000) begin
      @(negedge clk);
      cycles++;
    end
    if (!drive_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule